// File: doc/BRIEF.md
# Byte-Addressed Multi-Port GPIO Controller

This block is a memory-mapped general-purpose I/O controller that serves several 32-bit ports. By default it has eight ports, which gives 256 pins. Each pin has its own byte-wide data location, and its address is the pin's linear number. Software can therefore set, clear or sample a single pin with one byte access, and needs no read-modify-write of a shared word. Each port also has a 32-bit direction word, placed in a separate address window. The direction word decides whether each pin drives its output or is sampled as an input.

The register bus is simple and synchronous. Each cycle it carries an address, a write strobe, a byte of write data for pin locations and a word of write data for direction registers. Read data comes back registered, one cycle after the address is presented. Pin inputs pass through a two-flop synchroniser before any logic uses them. The output latch and direction values go straight to registered `pin_out` and `pin_oe` ports.

Top module: `gpio_bytewide_ctrl`

## Requirements
- R1: While the synchronous active-high reset `rst` is held, and in the first cycle after it, `pin_out`, `pin_oe` and `bus_rdata` are all zero. Every pin starts as an input with its output latch at 0.
- R2: A write to byte offset n, where n = port*32 + bit and n < 256, sets `pin_out[n]` to 1 in the cycle after the write if `bus_wbyte` is nonzero, and to 0 if it is zero.
- R3: A read of a pin offset returns the pin value in `bus_rdata[0]`, with `bus_rdata[31:1]` equal to zero.
- R4: A write to offset 0x2000 + 4*p (p < 8) loads `bus_wword` into the direction word of port p. Bit b set to 1 makes `pin_oe[p*32+b]` high (an output) from the next cycle, and 0 makes the pin an input.
- R5: A read of offset 0x2000 + 4*p returns that port's direction word in full.
- R6: A read of a pin whose direction bit is 1 returns its output latch value.
- R7: A read of a pin whose direction bit is 0 returns `pin_in` after two synchronising flops. A change on `pin_in` therefore first shows in `bus_rdata` three clock edges later.
- R8: Any other offset reads as zero and ignores writes. This covers 0x100–0x1FFF, direction offsets that are not word-aligned, and 0x2020 and above.
- R9: `bus_rdata` is registered. It shows the location addressed in the previous cycle, as that location stood before any write made in that same cycle.
- R10: A pin's output latch keeps its value while the pin is an input, and appears on `pin_out` and in pin reads whatever the direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 14 | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wbyte | input | 8 | Write data for pin locations |
| bus_wword | input | 32 | Write data for direction words |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 256 | Raw pin levels, asynchronous |
| pin_out | output | 256 | Output latch per pin |
| pin_oe | output | 256 | Output enable per pin (direction bit) |

## Verification
The bench targets these corner cases and the failure each would show:

| Corner case | What a wrong design would show |
|---|---|
| First and last pin (0 and 255) and pins at port boundaries | A decoder that slices the pin index wrongly drives the neighbouring port's pin. |
| Nonzero write bytes other than 1 | A design that stores only bit 0 drives 0x02 or 0xA4 as a low pin. |
| Unaligned direction offsets, offset 0x2020 and the gap just below 0x2000 | A loose decoder lets these writes corrupt a direction word or return stale data. |
| Reads in the same cycle as a write to the same location | A bypassing read path returns the new value instead of the old one. |
| Pin-level changes timed against reads | A missing synchroniser stage moves the change one cycle early. |
| A direction flip | A design that drops the latch while the pin is an input shows a stale level. |

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PIN  = 2'd1,
    SEL_DIR  = 2'd2
  } gpio_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_decode.sv
module gpio_decode
  import gpio_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = 32,
  parameter int DIR_BASE  = 'h2000
) (
  input  logic [ADDR_W-1:0]                    addr,
  output gpio_sel_e                            sel,
  output logic [$clog2(NUM_PORTS*PORT_W)-1:0]  pin_idx,
  output logic [$clog2(NUM_PORTS)-1:0]         dir_port
);
  localparam int NPINS   = NUM_PORTS * PORT_W;
  localparam int PIN_W   = $clog2(NPINS);
  localparam int PORT_IW = $clog2(NUM_PORTS);
  localparam int DIR_END = DIR_BASE + 4 * NUM_PORTS;

  logic [ADDR_W-1:0] dir_off;

  always_comb begin
    dir_off  = addr - ADDR_W'(DIR_BASE);
    pin_idx  = addr[PIN_W-1:0];
    dir_port = dir_off[2 +: PORT_IW];
    if (32'(addr) < NPINS)
      sel = SEL_PIN;
    else if (32'(addr) >= DIR_BASE && 32'(addr) < DIR_END && addr[1:0] == 2'b00)
      sel = SEL_DIR;
    else
      sel = SEL_NONE;
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int PORT_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      pin_we,
  input  logic [$clog2(PORT_W)-1:0] pin_bit,
  input  logic [7:0]                wbyte,
  input  logic                      dir_we,
  input  logic [PORT_W-1:0]         wword,
  output logic [PORT_W-1:0]         out_q,
  output logic [PORT_W-1:0]         dir_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      dir_q <= '0;
    end else begin
      if (pin_we)
        out_q[pin_bit] <= |wbyte;
      if (dir_we)
        dir_q <= wword;
    end
  end

  // R4
  dir_load_chk: assert property (@(posedge clk) disable iff (rst)
    dir_we |=> (dir_q == $past(wword)));

  // R10
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!pin_we && !$past(rst)) |=> $stable(out_q));
endmodule

// File: rtl/gpio_bytewide_ctrl.sv
module gpio_bytewide_ctrl
  import gpio_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = 32,
  parameter int DIR_BASE  = 'h2000
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_we,
  input  logic [7:0]                    bus_wbyte,
  input  logic [PORT_W-1:0]             bus_wword,
  output logic [PORT_W-1:0]             bus_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0]   pin_in,
  output logic [NUM_PORTS*PORT_W-1:0]   pin_out,
  output logic [NUM_PORTS*PORT_W-1:0]   pin_oe
);
  localparam int NPINS   = NUM_PORTS * PORT_W;
  localparam int PIN_W   = $clog2(NPINS);
  localparam int BIT_W   = $clog2(PORT_W);
  localparam int PORT_IW = $clog2(NUM_PORTS);

  gpio_sel_e          sel;
  logic [PIN_W-1:0]   pin_idx;
  logic [PORT_IW-1:0] dir_port;
  logic [NPINS-1:0]   pin_sync;
  logic [PORT_W-1:0]  rd_next;
  logic [PORT_W-1:0]  rdata_q;

  gpio_decode #(
    .ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .DIR_BASE(DIR_BASE)
  ) u_decode (
    .addr(bus_addr), .sel(sel), .pin_idx(pin_idx), .dir_port(dir_port)
  );

  gpio_sync #(.WIDTH(NPINS)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(pin_sync)
  );

  logic [PORT_IW-1:0] pin_port;
  logic [BIT_W-1:0]   pin_bit;
  assign pin_port = pin_idx[PIN_W-1:BIT_W];
  assign pin_bit  = pin_idx[BIT_W-1:0];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic pin_we_p;
    logic dir_we_p;
    assign pin_we_p = bus_we && (sel == SEL_PIN) && (pin_port == PORT_IW'(p));
    assign dir_we_p = bus_we && (sel == SEL_DIR) && (dir_port == PORT_IW'(p));

    gpio_port #(.PORT_W(PORT_W)) u_port (
      .clk(clk), .rst(rst),
      .pin_we(pin_we_p), .pin_bit(pin_bit), .wbyte(bus_wbyte),
      .dir_we(dir_we_p), .wword(bus_wword),
      .out_q(pin_out[p*PORT_W +: PORT_W]),
      .dir_q(pin_oe[p*PORT_W +: PORT_W])
    );
  end

  always_comb begin
    rd_next = '0;
    case (sel)
      SEL_PIN: rd_next[0] = pin_oe[pin_idx] ? pin_out[pin_idx] : pin_sync[pin_idx];
      SEL_DIR: rd_next = pin_oe[32'(dir_port)*PORT_W +: PORT_W];
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

  assign bus_rdata = rdata_q;

  logic pin_wr_hit;
  logic none_hit;
  assign pin_wr_hit = bus_we && (sel == SEL_PIN);
  assign none_hit   = (sel == SEL_NONE);

  // R2
  pin_write_chk: assert property (@(posedge clk) disable iff (rst)
    pin_wr_hit |=> (pin_out[$past(pin_idx)] == $past(|bus_wbyte)));

  // R3
  pin_read_width_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_PIN) |=> (bus_rdata[PORT_W-1:1] == '0));

  // R8
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    none_hit |=> (bus_rdata == '0));

  // R8
  unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && none_hit && !$past(rst)) |=> ($stable(pin_out) && $stable(pin_oe)));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (pin_out == '0 && pin_oe == '0 && bus_rdata == '0));
endmodule

// File: tb/test_gpio_bytewide_ctrl.sv
module test_gpio_bytewide_ctrl;
  localparam int NPINS = 256;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [13:0]       bus_addr = '0;
  logic              bus_we = 1'b0;
  logic [7:0]        bus_wbyte = '0;
  logic [31:0]       bus_wword = '0;
  logic [31:0]       bus_rdata;
  logic [NPINS-1:0]  pin_in = '0;
  logic [NPINS-1:0]  pin_out;
  logic [NPINS-1:0]  pin_oe;

  always #2 clk = ~clk;

  gpio_bytewide_ctrl i_gpio_bytewide_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wbyte(bus_wbyte), .bus_wword(bus_wword), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  int compared = 0;
  int mismatched = 0;

  bit [NPINS-1:0] m_out, m_dir, m_s1, m_s2;
  bit [31:0]      m_rdata;
  string          m_tag = "R1";
  bit             m_live = 0;

  always @(posedge clk) begin
    int a;
    bit [31:0] rd;
    string tag;
    a = int'(bus_addr);
    rd = 0;
    if (rst) begin
      m_out = '0; m_dir = '0; m_s1 = '0; m_s2 = '0; m_rdata = 0;
      m_tag = "R1";
    end else begin
      if (a < NPINS) begin
        if (m_dir[a]) begin rd[0] = m_out[a]; tag = "R3,R6,R10"; end
        else          begin rd[0] = m_s2[a];  tag = "R3,R7"; end
      end else if (a >= 'h2000 && a < 'h2020 && (a % 4) == 0) begin
        rd = m_dir[((a - 'h2000) / 4) * 32 +: 32];
        tag = "R5";
      end else begin
        tag = "R8";
      end
      if (bus_we) tag = {tag, ",R9"};
      m_rdata = rd;
      m_tag = tag;
      if (bus_we) begin
        if (a < NPINS) m_out[a] = (bus_wbyte != 0);
        else if (a >= 'h2000 && a < 'h2020 && (a % 4) == 0)
          m_dir[((a - 'h2000) / 4) * 32 +: 32] = bus_wword;
      end
      m_s2 = m_s1;
      m_s1 = pin_in;
    end
    m_live = 1;
  end

  always @(negedge clk) begin
    if (m_live) begin
      compared++;
      if (bus_rdata !== m_rdata) begin
        mismatched++;
        $display("FAIL %s rdata actual=%h expected=%h", m_tag, bus_rdata, m_rdata);
      end
      compared++;
      if (pin_out !== m_out) begin
        mismatched++;
        $display("FAIL R2,R10,R8 pin_out actual=%h expected=%h", pin_out, m_out);
      end
      compared++;
      if (pin_oe !== m_dir) begin
        mismatched++;
        $display("FAIL R4,R8 pin_oe actual=%h expected=%h", pin_oe, m_dir);
      end
    end
  end

  task automatic acc(input int addr, input bit we, input bit [7:0] b, input bit [31:0] w);
    @(negedge clk);
    bus_addr = 14'(addr); bus_we = we; bus_wbyte = b; bus_wword = w;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) acc('h3FFF, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    // R1: reset state observed during and after reset
    repeat (4) @(negedge clk);
    rst = 1'b0;
    acc(0, 0, 0, 0);
    acc('h2000, 0, 0, 0);
    // R2: writes with assorted nonzero and zero bytes, boundary pins
    acc(0, 1, 8'h01, 0);
    acc(255, 1, 8'hA4, 0);
    acc(31, 1, 8'h02, 0);
    acc(32, 1, 8'h80, 0);
    acc(37, 1, 8'h00, 0);
    acc(31, 1, 8'h00, 0);
    // R7: input reads with changing levels
    pin_in[5] = 1'b1; pin_in[200] = 1'b1;
    for (int i = 0; i < 4; i++) acc(5, 0, 0, 0);
    for (int i = 0; i < 3; i++) acc(200, 0, 0, 0);
    // R4 R5: direction words at first and last port
    acc('h2000, 1, 0, 32'h8000_0021);
    acc('h201C, 1, 0, 32'hFFFF_0001);
    acc('h2000, 0, 0, 0);
    acc('h201C, 0, 0, 0);
    // R6 R10: output pins read latch, including latch set while input
    acc(0, 0, 0, 0);
    acc(255, 0, 0, 0);
    acc(5, 0, 0, 0);
    // R9: read and write same location in one cycle
    acc(0, 1, 8'h00, 0);
    acc(0, 0, 0, 0);
    acc('h2004, 1, 0, 32'h1234_5678);
    acc('h2004, 1, 0, 32'h0);
    acc('h2004, 0, 0, 0);
    // R8: unmapped offsets ignore writes and read zero
    acc('h100, 1, 8'hFF, 32'hFFFF_FFFF);
    acc('h1FFF, 1, 8'hFF, 32'hFFFF_FFFF);
    acc('h2001, 1, 8'hFF, 32'hFFFF_FFFF);
    acc('h2002, 1, 8'hFF, 32'hFFFF_FFFF);
    acc('h2020, 1, 8'hFF, 32'hFFFF_FFFF);
    acc('h3FFC, 1, 8'hFF, 32'hFFFF_FFFF);
    acc('h2001, 0, 0, 0);
    acc('h2000, 0, 0, 0);
    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      int sel;
      int a;
      sel = $urandom_range(0, 9);
      if (sel < 6)      a = $urandom_range(0, 255);
      else if (sel < 8) a = 'h2000 + 4 * $urandom_range(0, 7);
      else              a = $urandom_range(256, 'h3FFF);
      if ($urandom_range(0, 15) == 0) pin_in = {8{$urandom()}};
      acc(a, $urandom_range(0, 2) == 0, 8'($urandom()), $urandom());
    end
    idle(4);
    // R1: reset clears everything again
    @(negedge clk); rst = 1'b1;
    idle(3);
    @(negedge clk); rst = 1'b0;
    idle(3);
    finish_run();
  end
endmodule